// File: doc/BRIEF.md
# Mode Register Bank with Write Guard

This block keeps the configuration words of a memory device. A controller writes one word at a time by raising a set strobe together with a 4-bit register number and a 12-bit opcode. Only certain register numbers exist. One register leaves reset with a non-zero value. Some bits of some registers must always be written as zero. All stored words are presented side by side on one wide output bus, so that downstream logic can decode the fields it needs. That decoding is not part of this block.

The block also checks each write before it takes effect. A write is taken only when the memory reports that every bank is idle and no burst is in flight, no earlier write is still settling, the register number exists, and no reserved bit is set. A write that is taken starts a settle window of a fixed number of clock cycles, and the block reports busy during that window. A write that is refused changes nothing. It raises an error flag for one cycle.

Top module: `mode_reg_bank`

## Requirements
- R1: After reset, every register reads zero except register 4, which reads 0x00F. Busy and error are both low.
- R2: Registers 0 to 6 and 15 are implemented. When a write is accepted, the opcode appears on `regs_flat[12*a +: 12]` in the cycle after the strobe, and only register `a` changes.
- R3: A write to any address from 7 to 14 is refused, and error is high in the cycle after the strobe. The slots for those addresses always read zero.
- R4: A write made while `banks_idle` is low is refused and raises error in the next cycle.
- R5: An accepted write drives busy high for exactly `SETTLE_CYC` cycles (4 by default), starting in the cycle after the strobe.
- R6: A write made while busy is high is refused and raises error. The first write made after busy has dropped is accepted.
- R7: Each register has its own reserved bits: register 2 bit 11, register 5 bits 11:10, and register 15 bits 11:8. The other registers have no reserved bits. A write that sets any reserved bit of its target register is refused and raises error.
- R8: A stored value stays unchanged through idle cycles and through writes to other registers. Asserting `rst_n` restores the R1 values at once, without waiting for a clock edge.
- R9: Error is high only in the cycle after a refused strobe. A refused write changes no register and does not start busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mrs_req | input | 1 | Mode-register write strobe, one cycle per write |
| mrs_addr | input | 4 | Target register number |
| mrs_op | input | 12 | Opcode to store |
| banks_idle | input | 1 | High when all banks are idle and no burst is active |
| regs_flat | output | 192 | All 16 register slots; slot `a` is at bits `12*a +: 12` |
| busy | output | 1 | High during the settle window after an accepted write |
| err | output | 1 | One-cycle pulse after a refused write |

## Verification
The hardest case to reach from the ports is a second write that lands in one particular cycle of the settle window, including the cycle right after the window closes. The bench places a write into register 1 and then a write into register 3, separated by every gap from one cycle to one cycle past the window length. This shows that the window is refused at every gap inside it and accepted exactly at its end. The reserved-bit rule is covered by walking a single set bit across all twelve positions for every address. That sweep keeps legal and illegal opcodes mixed on the same registers.

// File: rtl/mr_pkg.sv
package mr_pkg;
  localparam int MR_ADDR_W     = 4;
  localparam int MR_DATA_W     = 12;
  localparam int MR_SLOTS      = 1 << MR_ADDR_W;
  localparam int MR_SETTLE_DEF = 4;

  // implemented slots: 0..6 and 15
  localparam logic [MR_SLOTS-1:0] MR_IMPL_DEF = 16'h807F;

  // reserved bits per slot, slot 15 leftmost
  localparam logic [MR_SLOTS*MR_DATA_W-1:0] MR_RSV_DEF = {
    12'hF00, {8{12'h000}}, 12'h000, 12'hC00, 12'h000,
    12'h000, 12'h800, 12'h000, 12'h000};

  // reset values per slot, slot 15 leftmost: slot 4 low nibble set
  localparam logic [MR_SLOTS*MR_DATA_W-1:0] MR_RST_DEF = {
    {11{12'h000}}, 12'h00F, {4{12'h000}}};
endpackage

// File: rtl/mr_rst_sync.sv
module mr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/mr_guard.sv
module mr_guard #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 12,
  parameter int SETTLE_CYC = 4,
  parameter logic [(1<<ADDR_W)-1:0]        IMPL_MAP = '1,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] RSV_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] op_i,
  input  logic              idle_i,
  output logic              accept_o,
  output logic              err_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic              err_d;
  logic              slot_live, rsv_hit;
  logic [DATA_W-1:0] rsv_bits;

  always_comb begin
    slot_live = IMPL_MAP[addr_i];
    rsv_bits  = RSV_MASK[int'(addr_i)*DATA_W +: DATA_W];
    rsv_hit   = |(op_i & rsv_bits);
    busy_o    = (cnt_q != '0);
    accept_o  = req_i & slot_live & idle_i & ~busy_o & ~rsv_hit;
    err_d     = req_i & ~accept_o;
    cnt_en    = accept_o | busy_o;
    cnt_d     = accept_o ? CNT_W'(SETTLE_CYC) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= err_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/mr_slot_array.sv
module mr_slot_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12,
  parameter logic [(1<<ADDR_W)-1:0]        IMPL_MAP = '1,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] RST_VAL  = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               op_i,
  output logic [(1<<ADDR_W)*DATA_W-1:0]   regs_o
);
  localparam int SLOTS = 1 << ADDR_W;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (IMPL_MAP[g]) begin : g_live
      logic [DATA_W-1:0] val_q, val_d;
      logic              hit;

      always_comb begin
        hit   = we_i && (addr_i == ADDR_W'(g));
        val_d = op_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val_q <= RST_VAL[g*DATA_W +: DATA_W];
        else if (hit) val_q <= val_d;
      end

      assign regs_o[g*DATA_W +: DATA_W] = val_q;
    end else begin : g_hole
      assign regs_o[g*DATA_W +: DATA_W] = '0;
    end
  end
endmodule

// File: rtl/mode_reg_bank.sv
module mode_reg_bank #(
  parameter int ADDR_W     = mr_pkg::MR_ADDR_W,
  parameter int DATA_W     = mr_pkg::MR_DATA_W,
  parameter int SETTLE_CYC = mr_pkg::MR_SETTLE_DEF,
  parameter logic [(1<<ADDR_W)-1:0]        IMPL_MAP = mr_pkg::MR_IMPL_DEF,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] RSV_MASK = mr_pkg::MR_RSV_DEF,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] RST_VAL  = mr_pkg::MR_RST_DEF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mrs_req,
  input  logic [ADDR_W-1:0]             mrs_addr,
  input  logic [DATA_W-1:0]             mrs_op,
  input  logic                          banks_idle,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regs_flat,
  output logic                          busy,
  output logic                          err
);
  logic rst_sync_n;
  logic wr_accept;

  mr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  mr_guard #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC),
    .IMPL_MAP(IMPL_MAP), .RSV_MASK(RSV_MASK)
  ) u_guard (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_i    (mrs_req),
    .addr_i   (mrs_addr),
    .op_i     (mrs_op),
    .idle_i   (banks_idle),
    .accept_o (wr_accept),
    .err_o    (err),
    .busy_o   (busy)
  );

  mr_slot_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IMPL_MAP(IMPL_MAP), .RST_VAL(RST_VAL)
  ) u_slots (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we_i   (wr_accept),
    .addr_i (mrs_addr),
    .op_i   (mrs_op),
    .regs_o (regs_flat)
  );
endmodule

// File: rtl/mode_reg_bank_chk.sv
module mode_reg_bank_chk #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 12,
  parameter int SETTLE_CYC = 4,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MAP = '1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          mrs_req,
  input logic                          banks_idle,
  input logic [(1<<ADDR_W)*DATA_W-1:0] regs_flat,
  input logic                          busy,
  input logic                          err
);
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  for (genvar g = 0; g < (1<<ADDR_W); g++) begin : g_hole_chk
    if (!IMPL_MAP[g]) begin : g_h
      AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        regs_flat[g*DATA_W +: DATA_W] == '0); // R3
    end
  end

  AST_CHANGE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_flat) |-> busy); // R2
  AST_IDLE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_req && !banks_idle |=> err); // R4
  AST_BUSY_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= SETTLE_CYC); // R5
  AST_BUSY_LEN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_run == SETTLE_CYC); // R5
  AST_BUSY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_req && busy |=> err); // R6
  AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(regs_flat)); // R9
  AST_ERR_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(mrs_req)); // R9
endmodule

bind mode_reg_bank mode_reg_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC), .IMPL_MAP(IMPL_MAP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .mrs_req    (mrs_req),
  .banks_idle (banks_idle),
  .regs_flat  (regs_flat),
  .busy       (busy),
  .err        (err)
);

// File: tb/tb_mode_reg_bank.sv
module tb_mode_reg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int TMRD       = 4;
  localparam int WD_CYCLES  = 50000;

  logic         clk, rst_n, mrs_req, banks_idle;
  logic [3:0]   mrs_addr;
  logic [11:0]  mrs_op;
  logic [191:0] regs_flat;
  logic         busy, err;

  int checks = 0;
  int fails  = 0;
  logic [11:0] model [16];
  int busy_left = 0;

  mode_reg_bank dut (
    .clk(clk), .rst_n(rst_n), .mrs_req(mrs_req), .mrs_addr(mrs_addr),
    .mrs_op(mrs_op), .banks_idle(banks_idle), .regs_flat(regs_flat),
    .busy(busy), .err(err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic bit impl(input logic [3:0] a);
    return (a <= 4'd6) || (a == 4'd15);
  endfunction

  function automatic logic [11:0] rsv(input logic [3:0] a);
    case (a)
      4'd2:    return 12'h800;
      4'd5:    return 12'hC00;
      4'd15:   return 12'hF00;
      default: return 12'h000;
    endcase
  endfunction

  function automatic logic [191:0] flat();
    logic [191:0] f;
    for (int i = 0; i < 16; i++) f[i*12 +: 12] = model[i];
    return f;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) model[i] = (i == 4) ? 12'h00F : 12'h000;
    busy_left = 0;
  endtask

  task automatic chk(input bit ok, input string tag,
                     input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge act, compare at the next falling edge
  task automatic cyc(input logic req, input logic [3:0] a, input logic [11:0] op,
                     input logic idle, input string tag);
    bit legal;
    bit exp_err;
    mrs_req = req; mrs_addr = a; mrs_op = op; banks_idle = idle;
    @(posedge clk);
    legal   = req && impl(a) && idle && (busy_left == 0) && ((op & rsv(a)) == 12'h0);
    exp_err = req && !legal;
    if (legal) begin
      model[a]  = op;
      busy_left = TMRD;
    end else if (busy_left > 0) begin
      busy_left--;
    end
    @(negedge clk);
    mrs_req = 1'b0;
    chk(err == exp_err, tag, 192'(err), 192'(exp_err));
    chk(busy == (busy_left != 0), "R5", 192'(busy), 192'(busy_left != 0));
    chk(regs_flat == flat(), tag, regs_flat, flat());
  endtask

  task automatic drain();
    while (busy_left > 0) cyc(1'b0, 4'd0, 12'h000, 1'b1, "R9");
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hang exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    string tg;
    logic [11:0] ops [14];
    rst_n = 1'b0; mrs_req = 1'b0; mrs_addr = '0; mrs_op = '0; banks_idle = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(regs_flat == flat(), "R1", regs_flat, flat());
    chk(busy == 1'b0, "R1", 192'(busy), 192'(0));
    chk(err == 1'b0, "R1", 192'(err), 192'(0));

    // R2 R3 R7: sweep every address with walking-one and dense opcodes
    for (int b = 0; b < 12; b++) ops[b] = 12'(1 << b);
    ops[12] = 12'hFFF;
    ops[13] = 12'h5A5;
    for (int a = 0; a < 16; a++) begin
      for (int k = 0; k < 14; k++) begin
        if (!impl(4'(a)))                    tg = "R3";
        else if ((ops[k] & rsv(4'(a))) != 0) tg = "R7";
        else                                 tg = "R2";
        cyc(1'b1, 4'(a), ops[k] ^ 12'(a), 1'b1, tg);
        drain();
      end
    end

    // R4: not idle, every address
    for (int a = 0; a < 16; a++) cyc(1'b1, 4'(a), 12'h0F0, 1'b0, "R4");

    // R6: second write at every gap across the settle window
    for (int d = 1; d <= TMRD + 1; d++) begin
      cyc(1'b1, 4'd1, 12'(d), 1'b1, "R6");
      for (int i = 1; i < d; i++) cyc(1'b0, 4'd0, 12'h000, 1'b1, "R6");
      cyc(1'b1, 4'd3, 12'hA00 | 12'(d), 1'b1, "R6");
      drain();
    end

    // R8: values hold with noisy address/opcode and no strobe
    for (int i = 0; i < 20; i++) cyc(1'b0, 4'(i), 12'(i * 37), 1'(i & 1), "R8");
    // R8: writes to one register leave the others
    cyc(1'b1, 4'd6, 12'h3C3, 1'b1, "R8");
    drain();
    cyc(1'b1, 4'd15, 12'h0AB, 1'b1, "R8");
    drain();

    // R8: asynchronous reset mid-run restores reset values at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_reset();
    chk(regs_flat == flat(), "R8", regs_flat, flat());
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(regs_flat == flat(), "R1", regs_flat, flat());
    cyc(1'b1, 4'd4, 12'h000, 1'b1, "R2");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule